// File: doc/BRIEF.md
# Byte-Code Command Sequencer

The block runs short programs kept in a shared byte-wide SRAM. A mailbox gives it an entry address and a start pulse. The engine then reads one-byte opcodes and any inline operands from that address onward, in order, and stops at the end opcode. Each opcode either sends a one-cycle strobe to a neighbouring sampling and statistics unit, or loads a value into that unit. The values are a channel enable mask and a timer reload byte. Two opcodes write data back into the SRAM at an address taken from the program: one writes the statistics records of the enabled channels, the other writes a small information record.

The SRAM port has registered outputs and a one-cycle read latency. Each program byte takes three cycles to fetch, and each byte written back takes one cycle. The statistics unit shows one channel's record on a parallel bus, and the block picks the channel with a select output. Multi-byte values, both in operands and in written data, use big-endian order. An opcode the block does not know, or an access past the last SRAM address, ends the program with the error flag set.

Top module: `bcseq_top`

## Requirements
- R1: After reset, accept, done, err, every strobe, mem_rd and mem_wr are low, and mask_val and timer_val are zero.
- R2: A go pulse while idle gives an accept pulse on the next cycle. A go pulse while a program runs is ignored. done pulses for one cycle only after the end opcode (0x00) or an error.
- R3: Opcodes 0x10, 0x11 and 0x12 each give a one-cycle pulse on stat_clear, stat_start and stat_stop, in that order of mapping. Pulses follow the program order.
- R4: Opcode 0x14 reads two operand bytes, high byte first. It loads them as mask_val and pulses mask_load once.
- R5: Opcode 0x15 reads four operand bytes. It loads the second one as timer_val and pulses timer_load once.
- R6: Opcode 0x13 reads one address byte. From that address it writes the 11-byte record of each enabled channel, in ascending channel order, with no gaps. A record's first byte is rec_data[87:80] and its last byte is rec_data[7:0]. Nothing is written past the final record.
- R7: Opcode 0x31 reads one address byte and writes 10 bytes there. In order these are: version high, version low, prescale (0), timer_val, number of set bits in mask_val, record address high, record address low, and three zero bytes.
- R8: An opcode not listed in R3 to R7 ends the program with done and err. No opcode after it takes effect.
- R9: A fetch from address 0x100 or beyond ends the program with err. A write-back that reaches 0x100 also ends it with err, after the bytes up to 0xFF are written.
- R10: err stays high until the next accepted program, which clears it. A program that ends normally leaves err low.
- R11: Opcode 0x13 with an all-zero mask writes no byte, and the program goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse from the mailbox |
| entry_addr | input | 8 | Program start address |
| accept | output | 1 | Program accepted (one-cycle pulse) |
| done | output | 1 | Program finished (one-cycle pulse) |
| err | output | 1 | Last program ended in error |
| mem_rd | output | 1 | SRAM read request |
| mem_wr | output | 1 | SRAM write request |
| mem_addr | output | 8 | SRAM address |
| mem_wdata | output | 8 | SRAM write data |
| mem_rdata | input | 8 | SRAM read data, one cycle after mem_rd |
| stat_stop | output | 1 | Stop collection strobe |
| stat_clear | output | 1 | Clear statistics strobe |
| stat_start | output | 1 | Start collection strobe |
| mask_load | output | 1 | Mask load strobe |
| mask_val | output | 16 | Channel enable mask |
| timer_load | output | 1 | Timer load strobe |
| timer_val | output | 8 | Timer reload value |
| rec_sel | output | 4 | Channel whose record is being read |
| rec_data | input | 88 | Selected channel's record, first byte in the top bits |

## Verification
The bench uses a sparse mask with channels 1, 8 and 15. A wrong channel scan would drop or repeat a record, and a missing end check would write one byte past the last record. It checks that the timer takes the second of four operands; an off-by-one in operand counting would pick a neighbouring byte or misread the following opcode. It places a program at the top of memory and a write-back that runs over the end. A design without bounds checks would wrap to address zero and keep running instead of setting err. Other tests cover an unknown opcode in mid-program, a go pulse during a run, and an empty mask. These catch designs that run on after an error, restart while busy, or write a phantom record.

// File: rtl/bcseq_pkg.sv
package bcseq_pkg;
  localparam logic [7:0] OP_END   = 8'h00;
  localparam logic [7:0] OP_CLEAR = 8'h10;
  localparam logic [7:0] OP_START = 8'h11;
  localparam logic [7:0] OP_STOP  = 8'h12;
  localparam logic [7:0] OP_DUMP  = 8'h13;
  localparam logic [7:0] OP_MASK  = 8'h14;
  localparam logic [7:0] OP_TIMER = 8'h15;
  localparam logic [7:0] OP_INFO  = 8'h31;

  localparam int REC_BYTES  = 11;
  localparam int INFO_BYTES = 10;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_RD_USE, S_WRITE, S_FINISH
  } seq_state_t;
endpackage

// File: rtl/bcseq_chan_scan.sv
module bcseq_chan_scan #(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic [CW:0]    from,
  output logic           hit,
  output logic [CW-1:0]  idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(from))) begin
        hit = 1'b1;
        idx = CW'(i);
      end
    end
  end
endmodule

// File: rtl/bcseq_byte_mux.sv
module bcseq_byte_mux
  import bcseq_pkg::*;
#(
  parameter int          NCH      = 16,
  parameter logic [15:0] VERSION  = 16'h0203,
  parameter logic [15:0] REC_ADDR = 16'h0080,
  localparam int REC_W = 8 * REC_BYTES
) (
  input  logic             is_info,
  input  logic [3:0]       idx,
  input  logic [REC_W-1:0] rec_data,
  input  logic [7:0]       timer,
  input  logic [NCH-1:0]   mask,
  output logic [7:0]       wbyte,
  output logic             last
);
  logic [7:0] count;

  always_comb begin
    count = '0;
    for (int i = 0; i < NCH; i++) count = count + 8'(mask[i]);
  end

  always_comb begin
    wbyte = 8'h00;
    if (is_info) begin
      case (idx)
        4'd0: wbyte = VERSION[15:8];
        4'd1: wbyte = VERSION[7:0];
        4'd2: wbyte = 8'h00;
        4'd3: wbyte = timer;
        4'd4: wbyte = count;
        4'd5: wbyte = REC_ADDR[15:8];
        4'd6: wbyte = REC_ADDR[7:0];
        default: wbyte = 8'h00;
      endcase
    end else begin
      for (int k = 0; k < REC_BYTES; k++)
        if (int'(idx) == k) wbyte = rec_data[REC_W-1-8*k -: 8];
    end
    last = is_info ? (int'(idx) == INFO_BYTES - 1) : (int'(idx) == REC_BYTES - 1);
  end
endmodule

// File: rtl/bcseq_top.sv
module bcseq_top
  import bcseq_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          NCH      = 16,
  parameter logic [15:0] VERSION  = 16'h0203,
  parameter logic [15:0] REC_ADDR = 16'h0080,
  localparam int CW    = $clog2(NCH),
  localparam int REC_W = 8 * REC_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] entry_addr,
  output logic              accept,
  output logic              done,
  output logic              err,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              stat_stop,
  output logic              stat_clear,
  output logic              stat_start,
  output logic              mask_load,
  output logic [NCH-1:0]    mask_val,
  output logic              timer_load,
  output logic [7:0]        timer_val,
  output logic [CW-1:0]     rec_sel,
  input  logic [REC_W-1:0]  rec_data
);
  seq_state_t      state;
  logic [ADDR_W:0] pc;
  logic [ADDR_W:0] waddr;
  logic [7:0]      opc;
  logic            in_operand;
  logic [2:0]      need;
  logic [2:0]      ocnt;
  logic [15:0]     opnd;
  logic [3:0]      bidx;
  logic            wr_info;
  logic            err_pend;

  logic [CW:0]     scan_from;
  logic            scan_hit;
  logic [CW-1:0]   scan_idx;
  logic [7:0]      out_byte;
  logic            out_last;

  assign scan_from = (state == S_WRITE) ? ({1'b0, rec_sel} + 1'b1) : '0;

  bcseq_chan_scan #(.NCH(NCH)) u_scan (
    .mask (mask_val),
    .from (scan_from),
    .hit  (scan_hit),
    .idx  (scan_idx)
  );

  bcseq_byte_mux #(.NCH(NCH), .VERSION(VERSION), .REC_ADDR(REC_ADDR)) u_mux (
    .is_info  (wr_info),
    .idx      (bidx),
    .rec_data (rec_data),
    .timer    (timer_val),
    .mask     (mask_val),
    .wbyte    (out_byte),
    .last     (out_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      pc         <= '0;
      waddr      <= '0;
      opc        <= '0;
      in_operand <= 1'b0;
      need       <= '0;
      ocnt       <= '0;
      opnd       <= '0;
      bidx       <= '0;
      wr_info    <= 1'b0;
      err_pend   <= 1'b0;
      accept     <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      stat_stop  <= 1'b0;
      stat_clear <= 1'b0;
      stat_start <= 1'b0;
      mask_load  <= 1'b0;
      mask_val   <= '0;
      timer_load <= 1'b0;
      timer_val  <= '0;
      rec_sel    <= '0;
    end else begin
      accept     <= 1'b0;
      done       <= 1'b0;
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      stat_stop  <= 1'b0;
      stat_clear <= 1'b0;
      stat_start <= 1'b0;
      mask_load  <= 1'b0;
      timer_load <= 1'b0;
      case (state)
        S_IDLE: begin
          if (go) begin
            pc         <= {1'b0, entry_addr};
            accept     <= 1'b1;
            err        <= 1'b0;
            err_pend   <= 1'b0;
            in_operand <= 1'b0;
            state      <= S_RD_REQ;
          end
        end
        S_RD_REQ: begin
          if (pc[ADDR_W]) begin
            err_pend <= 1'b1;
            state    <= S_FINISH;
          end else begin
            mem_rd   <= 1'b1;
            mem_addr <= pc[ADDR_W-1:0];
            state    <= S_RD_WAIT;
          end
        end
        S_RD_WAIT: state <= S_RD_USE;
        S_RD_USE: begin
          pc    <= pc + 1'b1;
          state <= S_RD_REQ;
          if (!in_operand) begin
            opc  <= mem_rdata;
            ocnt <= '0;
            case (mem_rdata)
              OP_END:   state <= S_FINISH;
              OP_CLEAR: stat_clear <= 1'b1;
              OP_START: stat_start <= 1'b1;
              OP_STOP:  stat_stop  <= 1'b1;
              OP_DUMP, OP_INFO: begin need <= 3'd1; in_operand <= 1'b1; end
              OP_MASK:  begin need <= 3'd2; in_operand <= 1'b1; end
              OP_TIMER: begin need <= 3'd4; in_operand <= 1'b1; end
              default: begin
                err_pend <= 1'b1;
                state    <= S_FINISH;
              end
            endcase
          end else begin
            opnd <= {opnd[7:0], mem_rdata};
            ocnt <= ocnt + 1'b1;
            if (ocnt == need - 1'b1) begin
              in_operand <= 1'b0;
              case (opc)
                OP_MASK: begin
                  mask_val  <= NCH'({opnd[7:0], mem_rdata});
                  mask_load <= 1'b1;
                end
                OP_TIMER: begin
                  timer_val  <= opnd[15:8];
                  timer_load <= 1'b1;
                end
                OP_INFO: begin
                  waddr   <= {1'b0, mem_rdata};
                  wr_info <= 1'b1;
                  bidx    <= '0;
                  state   <= S_WRITE;
                end
                default: begin
                  waddr   <= {1'b0, mem_rdata};
                  wr_info <= 1'b0;
                  bidx    <= '0;
                  if (scan_hit) begin
                    rec_sel <= scan_idx;
                    state   <= S_WRITE;
                  end
                end
              endcase
            end
          end
        end
        S_WRITE: begin
          if (waddr[ADDR_W]) begin
            err_pend <= 1'b1;
            state    <= S_FINISH;
          end else begin
            mem_wr    <= 1'b1;
            mem_addr  <= waddr[ADDR_W-1:0];
            mem_wdata <= out_byte;
            waddr     <= waddr + 1'b1;
            if (out_last) begin
              bidx <= '0;
              if (!wr_info && scan_hit) rec_sel <= scan_idx;
              else                      state   <= S_RD_REQ;
            end else begin
              bidx <= bidx + 1'b1;
            end
          end
        end
        S_FINISH: begin
          done  <= 1'b1;
          err   <= err_pend;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: accept only answers a go seen while idle
  a_r2_accept_from_idle: assert property (@(posedge clk) disable iff (rst)
    accept |-> ($past(go) && $past(state == S_IDLE)));

  // R2: done is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: at most one statistics strobe per cycle
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stat_stop, stat_clear, stat_start, mask_load, timer_load}));

  // R6: the SRAM port never reads and writes together
  a_r6_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R8: err only rises together with done
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);

  // R9: no SRAM traffic once the engine is back at idle
  a_r9_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && $past(state == S_IDLE)) |-> (!mem_rd && !mem_wr));

  // R2: no strobe and no write while idle
  a_r2_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && $past(state == S_IDLE)) |->
      !(stat_stop || stat_clear || stat_start || mask_load || timer_load));
endmodule

// File: tb/bcseq_top_tb.sv
module bcseq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int REC_W = 88;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             go = 1'b0;
  logic [7:0]       entry_addr = '0;
  logic             accept, done, err, mem_rd, mem_wr;
  logic [7:0]       mem_addr, mem_wdata;
  logic [7:0]       mem_rdata = '0;
  logic             stat_stop, stat_clear, stat_start, mask_load, timer_load;
  logic [15:0]      mask_val;
  logic [7:0]       timer_val;
  logic [3:0]       rec_sel;
  logic [REC_W-1:0] rec_data;

  logic [7:0] mem [256];
  int checks = 0;
  int fails = 0;
  int log_n = 0;
  int log_q [64];
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcseq_top u_dut (
    .clk(clk), .rst(rst), .go(go), .entry_addr(entry_addr),
    .accept(accept), .done(done), .err(err),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .stat_stop(stat_stop), .stat_clear(stat_clear), .stat_start(stat_start),
    .mask_load(mask_load), .mask_val(mask_val),
    .timer_load(timer_load), .timer_val(timer_val),
    .rec_sel(rec_sel), .rec_data(rec_data)
  );

  function automatic logic [7:0] rec_byte(int ch, int k);
    return {4'(ch), 4'(k)};
  endfunction

  always_comb begin
    for (int k = 0; k < 11; k++) rec_data[REC_W-1-8*k -: 8] = rec_byte(int'(rec_sel), k);
  end

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  // strobe log: 1 clear, 2 start, 3 stop, 4 mask, 5 timer
  always @(negedge clk) begin
    cyc++;
    if (!rst && log_n < 64) begin
      if (stat_clear) begin log_q[log_n] = 1; log_n++; end
      if (stat_start) begin log_q[log_n] = 2; log_n++; end
      if (stat_stop)  begin log_q[log_n] = 3; log_n++; end
      if (mask_load)  begin log_q[log_n] = 4; log_n++; end
      if (timer_load) begin log_q[log_n] = 5; log_n++; end
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: act=%0d expected=<100000 cycles", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(logic [7:0] v);
    for (int i = 0; i < 256; i++) mem[i] = v;
  endtask

  task automatic run(logic [7:0] at);
    log_n = 0;
    @(negedge clk);
    go = 1'b1;
    entry_addr = at;
    @(negedge clk);
    go = 1'b0;
    check("R2 accept", 32'(accept), 32'd1);
    for (int n = 0; n < 3000 && !done; n++) @(negedge clk);
    check("R2 done", 32'(done), 32'd1);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 accept", 32'(accept), 0);
    check("R1 done", 32'(done), 0);
    check("R1 err", 32'(err), 0);
    check("R1 mem", 32'({mem_rd, mem_wr}), 0);
    check("R1 strobes", 32'({stat_stop, stat_clear, stat_start, mask_load, timer_load}), 0);
    check("R1 mask", 32'(mask_val), 0);
    check("R1 timer", 32'(timer_val), 0);
  endtask

  task automatic t_main;
    logic [7:0] prog [16] = '{8'h14, 8'h81, 8'h02, 8'h15, 8'h00, 8'h2A, 8'h00, 8'h00,
                              8'h12, 8'h10, 8'h11, 8'h13, 8'h40, 8'h31, 8'h90, 8'h00};
    logic [7:0] info [10] = '{8'h02, 8'h03, 8'h00, 8'h2A, 8'h03, 8'h00, 8'h80, 8'h00, 8'h00, 8'h00};
    int chans [3] = '{1, 8, 15};
    fill(8'hEE);
    for (int i = 0; i < 16; i++) mem[i] = prog[i];
    run(8'h00);
    check("R10 err low", 32'(err), 0);
    check("R4 mask", 32'(mask_val), 32'h8102);
    check("R5 timer", 32'(timer_val), 32'h2A);
    check("R3 log count", log_n, 5);
    check("R4 order", log_q[0], 4);
    check("R5 order", log_q[1], 5);
    check("R3 stop", log_q[2], 3);
    check("R3 clear", log_q[3], 1);
    check("R3 start", log_q[4], 2);
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 11; k++)
        check("R6 record byte", 32'(mem[8'h40 + c*11 + k]), 32'(rec_byte(chans[c], k)));
    check("R6 no overrun", 32'(mem[8'h40 + 33]), 32'hEE);
    for (int k = 0; k < 10; k++)
      check("R7 info byte", 32'(mem[8'h90 + k]), 32'(info[k]));
  endtask

  task automatic t_empty_mask;
    fill(8'hEE);
    mem[0] = 8'h14; mem[1] = 8'h00; mem[2] = 8'h00;
    mem[3] = 8'h13; mem[4] = 8'h50; mem[5] = 8'h11; mem[6] = 8'h00;
    run(8'h00);
    check("R11 nothing written", 32'(mem[8'h50]), 32'hEE);
    check("R11 next opcode runs", log_n, 2);
    check("R11 err low", 32'(err), 0);
  endtask

  task automatic t_bad_opcode;
    fill(8'hEE);
    mem[8'h20] = 8'h10; mem[8'h21] = 8'h77; mem[8'h22] = 8'h11; mem[8'h23] = 8'h00;
    run(8'h20);
    check("R8 err", 32'(err), 1);
    check("R8 only first strobe", log_n, 1);
    check("R8 first is clear", log_q[0], 1);
  endtask

  task automatic t_err_clear;
    mem[8'h30] = 8'h00;
    check("R10 err held", 32'(err), 1);
    run(8'h30);
    check("R10 err cleared", 32'(err), 0);
  endtask

  task automatic t_fetch_overflow;
    fill(8'hEE);
    mem[8'hFD] = 8'h10; mem[8'hFE] = 8'h10; mem[8'hFF] = 8'h10;
    run(8'hFD);
    check("R9 fetch err", 32'(err), 1);
    check("R9 top bytes run", log_n, 3);
  endtask

  task automatic t_write_overflow;
    fill(8'hEE);
    mem[0] = 8'h31; mem[1] = 8'hF8; mem[2] = 8'h11; mem[3] = 8'h00;
    run(8'h00);
    check("R9 write err", 32'(err), 1);
    check("R9 last byte written", 32'(mem[8'hFE]), 32'h80);
    check("R9 top byte written", 32'(mem[8'hFF]), 32'h00);
    check("R9 no wrap", 32'(mem[8'h04]), 32'hEE);
    check("R9 no later opcode", log_n, 0);
  endtask

  task automatic t_busy_go;
    fill(8'hEE);
    for (int i = 0; i < 12; i++) mem[i] = 8'h10;
    mem[12] = 8'h00;
    mem[8'h60] = 8'h11; mem[8'h61] = 8'h00;
    log_n = 0;
    @(negedge clk); go = 1'b1; entry_addr = 8'h00;
    @(negedge clk); go = 1'b0;
    check("R2 accept", 32'(accept), 1);
    repeat (5) @(negedge clk);
    go = 1'b1; entry_addr = 8'h60;
    @(negedge clk); go = 1'b0;
    check("R2 busy go ignored", 32'(accept), 0);
    for (int n = 0; n < 3000 && !done; n++) @(negedge clk);
    check("R2 done", 32'(done), 1);
    @(negedge clk);
    check("R2 first program only", log_n, 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_main();
    t_empty_mask();
    t_bad_opcode();
    t_err_clear();
    t_fetch_overflow();
    t_write_overflow();
    t_busy_go();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule